// File: doc/BRIEF.md
# Clear-on-read event counter bank

This block keeps four short event counters for a ring-network receive path: completed frames, tokens, format-error (lost) events and locatable errors. A frame classifier drives one-cycle increment pulses, one input per event kind. A host processor samples the counters through a small read port made of a 2-bit address, a read strobe and 8-bit read data.

The counters need only span the host's interrupt latency, because software adds each reading into its own full-width totals. Reading the frame, lost or error counter returns its value and clears it in the same edge. An increment that arrives in the cycle of that read is kept: the counter is left at one. As a result, no event is lost however the reads are timed. The token counter can be read but is never cleared by a read.

Top module: `evcnt_bank`

## Requirements
- R1: After the active-low asynchronous reset, every counter is zero and the read data output is zero.
- R2: Each cycle in which a counter's increment input is high and no read-clear of that counter happens, the counter rises by exactly one.
- R3: A counter holding 255 stays at 255 on further increments and does not wrap to zero.
- R4: When the read strobe is high at a clock edge, the read data output shows the addressed counter's value from before that edge, starting one cycle after the strobe. The output holds that value until the next strobe.
- R5: A read of the frame, lost or error counter clears that counter at the same edge.
- R6: If a read-clear and an increment of the same counter land in the same cycle, the counter holds one afterwards, and the returned data does not include that increment.
- R7: Reading the token counter leaves its value unchanged.
- R8: An increment or read-clear changes only the counter it addresses. The other counters keep their values.
- R9: Address 0 selects the frame counter, 1 the token counter, 2 the lost counter and 3 the error counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_inc_i | input | 1 | Frame event pulse |
| token_inc_i | input | 1 | Token event pulse |
| lost_inc_i | input | 1 | Format-error event pulse |
| error_inc_i | input | 1 | Locatable-error event pulse |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 2 | Counter select (0 frame, 1 token, 2 lost, 3 error) |
| rdata_o | output | 8 | Registered read data, valid one cycle after the strobe |

## Verification
Each counter's state is visible only through a read, so a wrong count, a lost same-cycle increment or a missing clear shows at rdata_o one cycle after the next strobe to that address. A bad clear shows one read later, when the second read still returns the old value. The bench reads the counters often and at irregular times, interleaved with random increments, so that an internal error shows up within a few cycles. A wrapping or stuck counter shows up in long increment bursts that run past 255.

// File: rtl/evcnt_pkg.sv
`timescale 1ns/1ps
package evcnt_pkg;
  localparam int CNT_W   = 8;
  localparam int ADDR_W  = 2;
  localparam int NUM_CNT = 2 ** ADDR_W;

  typedef enum logic [ADDR_W-1:0] {
    SEL_FRAME = 2'd0,
    SEL_TOKEN = 2'd1,
    SEL_LOST  = 2'd2,
    SEL_ERROR = 2'd3
  } cnt_sel_e;

  localparam int TOKEN_IDX = int'(SEL_TOKEN);
endpackage

// File: rtl/evcnt_cell.sv
`timescale 1ns/1ps
module evcnt_cell #(
  parameter int W      = 8,
  parameter bit CLR_EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, base, cnt_d;

  always_comb begin
    // clear first, then add: read+inc leaves 1
    base  = (CLR_EN && clr_i) ? '0 : cnt_q;
    cnt_d = (inc_i && base != MAX) ? base + W'(1) : base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evcnt_rdport.sv
`timescale 1ns/1ps
module evcnt_rdport #(
  parameter int W  = 8,
  parameter int AW = 2,
  localparam int N = 2 ** AW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [N-1:0][W-1:0] cnt_i,
  output logic [N-1:0]        clr_o,
  output logic [W-1:0]        rdata_o
);
  logic [W-1:0] rdata_q;

  for (genvar k = 0; k < N; k++) begin : g_dec
    assign clr_o[k] = rd_i && (addr_i == AW'(k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= cnt_i[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/evcnt_bank.sv
`timescale 1ns/1ps
module evcnt_bank
  import evcnt_pkg::*;
#(
  parameter int CNT_W = evcnt_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_inc_i,
  input  logic             token_inc_i,
  input  logic             lost_inc_i,
  input  logic             error_inc_i,
  input  logic             rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CNT_W-1:0] rdata_o
);
  logic [NUM_CNT-1:0]            inc_v;
  logic [NUM_CNT-1:0]            clr_v;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_v;

  always_comb begin
    inc_v             = '0;
    inc_v[SEL_FRAME]  = frame_inc_i;
    inc_v[SEL_TOKEN]  = token_inc_i;
    inc_v[SEL_LOST]   = lost_inc_i;
    inc_v[SEL_ERROR]  = error_inc_i;
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    evcnt_cell #(
      .W     (CNT_W),
      .CLR_EN(k != TOKEN_IDX)
    ) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (inc_v[k]),
      .clr_i (clr_v[k]),
      .cnt_o (cnt_v[k])
    );
  end

  evcnt_rdport #(
    .W (CNT_W),
    .AW(ADDR_W)
  ) u_rdport (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .addr_i (addr_i),
    .cnt_i  (cnt_v),
    .clr_o  (clr_v),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/evcnt_bank_chk.sv
`timescale 1ns/1ps
module evcnt_bank_chk #(
  parameter int W  = 8,
  parameter int AW = 2,
  localparam int N = 2 ** AW
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rd_i,
  input logic [AW-1:0]       addr_i,
  input logic [N-1:0]        inc_v,
  input logic [N-1:0][W-1:0] cnt_v,
  input logic [W-1:0]        rdata_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  // R1
  always_comb if (!rst_ni) reset_zero_chk: assert (rdata_o == '0 && cnt_v == '0);

  // R4
  rd_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rdata_o == $past(cnt_v[addr_i]));

  // R4
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  for (genvar k = 0; k < N; k++) begin : g_k
    // R2, R8
    step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(rd_i && addr_i == AW'(k)) && inc_v[k] && cnt_v[k] != MAX)
        |=> cnt_v[k] == $past(cnt_v[k]) + W'(1));

    // R8
    idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(rd_i && addr_i == AW'(k)) && !inc_v[k]) |=> $stable(cnt_v[k]));

    // R3
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_v[k] == MAX && !(rd_i && addr_i == AW'(k))) |=> cnt_v[k] == MAX);

    if (k == 1) begin : g_keep
      // R7
      token_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == AW'(k) && !inc_v[k]) |=> $stable(cnt_v[k]));
    end else begin : g_clr
      // R5, R6
      rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == AW'(k)) |=> cnt_v[k] == W'($past(inc_v[k])));
    end
  end
endmodule

bind evcnt_bank evcnt_bank_chk #(.W(CNT_W), .AW(evcnt_pkg::ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rd_i   (rd_i),
  .addr_i (addr_i),
  .inc_v  (inc_v),
  .cnt_v  (cnt_v),
  .rdata_o(rdata_o)
);

// File: tb/tb_evcnt_bank.sv
`timescale 1ns/1ps
module tb_evcnt_bank;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_inc_i = 1'b0, token_inc_i = 1'b0, lost_inc_i = 1'b0, error_inc_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] rdata_o;

  int checks = 0;
  int failures = 0;
  int model [4];
  int exp_rdata = 0;
  bit done = 0;

  always #5ns clk_i = ~clk_i;

  evcnt_bank dut (
    .clk_i, .rst_ni, .frame_inc_i, .token_inc_i, .lost_inc_i, .error_inc_i,
    .rd_i, .addr_i, .rdata_o
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // inc bits: [0] frame, [1] token, [2] lost, [3] error
  task automatic step(input logic [3:0] inc, input logic rd, input logic [1:0] a, input string tag);
    @(negedge clk_i);
    frame_inc_i = inc[0]; token_inc_i = inc[1]; lost_inc_i = inc[2]; error_inc_i = inc[3];
    rd_i = rd; addr_i = a;
    @(posedge clk_i);
    if (rd) exp_rdata = model[a];
    for (int k = 0; k < 4; k++) begin
      int v;
      v = (rd && a == 2'(k) && k != 1) ? 0 : model[k];
      if (inc[k] && v < 255) v++;
      model[k] = v;
    end
    #1ns;
    check(int'(rdata_o), exp_rdata, tag);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    step(4'b0000, 1'b1, a, tag);
  endtask

  initial begin
    #2_000_000ns;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) model[k] = 0;
    #1ns;
    check(int'(rdata_o), 0, "R1 rdata in reset");
    #20ns;
    @(negedge clk_i); rst_ni = 1'b1;
    // R1: all counters zero after reset
    for (int k = 0; k < 4; k++) rd(2'(k), "R1 read after reset");

    // R2, R9: frame counter at address 0
    repeat (5) step(4'b0001, 1'b0, 2'd0, "R2 frame inc");
    rd(2'd0, "R9 frame addr0");
    check(int'(rdata_o), 5, "R2 frame count 5");
    rd(2'd0, "R5 frame cleared");
    check(int'(rdata_o), 0, "R5 frame zero after read");

    // R7, R9: token counter, not cleared by read
    repeat (3) step(4'b0010, 1'b0, 2'd0, "R2 token inc");
    rd(2'd1, "R9 token addr1");
    check(int'(rdata_o), 3, "R7 token first read");
    rd(2'd1, "R7 token reread");
    check(int'(rdata_o), 3, "R7 token kept");

    // R3: lost saturates
    repeat (300) step(4'b0100, 1'b0, 2'd0, "R3 lost burst");
    rd(2'd2, "R3 lost saturated");
    check(int'(rdata_o), 255, "R3 lost at 255");
    rd(2'd2, "R5 lost cleared");
    check(int'(rdata_o), 0, "R5 lost zero");

    // R6: same-cycle read and increment
    repeat (4) step(4'b1000, 1'b0, 2'd0, "R2 error inc");
    step(4'b1000, 1'b1, 2'd3, "R6 read with inc");
    check(int'(rdata_o), 4, "R6 returned excludes inc");
    rd(2'd3, "R6 leftover");
    check(int'(rdata_o), 1, "R6 counter holds one");

    // R8: independence
    repeat (7) step(4'b1111, 1'b0, 2'd0, "R8 all inc");
    step(4'b0000, 1'b1, 2'd0, "R8 clear frame");
    rd(2'd2, "R8 lost untouched");
    check(int'(rdata_o), 7, "R8 lost is 7");
    rd(2'd3, "R8 error untouched");
    rd(2'd1, "R8 token untouched");
    check(int'(rdata_o), 10, "R8 token is 10");

    // R4: hold without strobe
    repeat (5) step(4'b1111, 1'b0, 2'd2, "R4 hold");
    check(int'(rdata_o), 10, "R4 rdata held");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] inc;
      inc = 4'($urandom);
      step(inc, ($urandom % 3) == 0, 2'($urandom), "R2 R5 R6 random");
    end
    for (int k = 0; k < 4; k++) rd(2'(k), "R9 final read");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule